// File: doc/BRIEF.md
# Eight-Channel TDM Audio Deserializer

This block takes eight channels of audio that arrive time-multiplexed on serial data lines. All lines share one bit clock and one frame clock, and the block runs directly on the bit clock. The frame clock marks the start of each frame. Each channel owns a 32-bit slot. The first 24 bits of the slot hold a two's complement sample, sent MSB first. The last 8 bits are padding.

A single mode input picks one of two layouts. In the long layout (256 bit clocks per frame), all eight slots come in on line 0. In the short layout (128 bit clocks per frame), line 0 carries channels 0 to 3 and line 1 carries channels 4 to 7, both on the same slot timing. All remaining data lines are ignored.

The block checks the length of every frame. A frame of the right length updates all eight parallel outputs together and raises a one-cycle completion strobe. A frame of any other length raises a one-cycle framing-error pulse and leaves the outputs as they were.

The controller has two states:
- S_WAIT_SYNC: after reset, until the first frame start.
- S_COLLECT: every cycle after that.

The transition S_WAIT_SYNC to S_COLLECT is taken on the first detected frame start. S_COLLECT loops on itself, and each later frame start closes the current frame and opens the next one.

Top module: `tdm8_deser`

## Requirements
- R1: While reset is low, and right after it is released, `samples` is all zero and `frame_done` and `frame_err` are low.
- R2: A frame start is a rising edge of `fsync`, seen as 0 at one rising `bclk` edge and 1 at the next. The MSB of slot 0 is sampled at the rising `bclk` edge after the edge where the frame start is detected.
- R3: With `mode_128`=0, slot k (k = 0..7) covers frame bits 32k to 32k+31 on `sdin[0]`. Bits 32k to 32k+23 form channel k, MSB first. Channel k appears at `samples[24k+23:24k]`.
- R4: With `mode_128`=1, slot k (k = 0..3) covers frame bits 32k to 32k+31. On `sdin[0]` the slot feeds channel k, and on `sdin[1]` the same slot feeds channel k+4, both MSB first.
- R5: The data lines a mode does not use have no effect on the outputs: `sdin[3:1]` in the 256 mode and `sdin[3:2]` in the 128 mode.
- R6: Bits 24 to 31 of every slot have no effect on the outputs.
- R7: When two frame starts are exactly 256 (mode 0) or 128 (mode 1) bit clocks apart, all eight channels load at once at the second start edge. `frame_done` is high for exactly one cycle after that edge. Outputs never change without `frame_done`.
- R8: When the spacing between two frame starts differs from the length for the current mode, `frame_err` pulses for one cycle, `frame_done` stays low, and `samples` keeps its previous value.
- R9: The first frame start after reset only arms the controller. It raises neither `frame_done` nor `frame_err`.
- R10: `frame_done` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to bclk |
| fsync | input | 1 | Frame clock; its rising edge starts a frame |
| mode_128 | input | 1 | 0: 256-bit single-line frame, 1: 128-bit dual-line frame |
| sdin | input | NLINES (4) | Serial data lines |
| samples | output | NCH*SAMPLE_W (192) | Parallel samples; channel k in bits 24k+23:24k |
| frame_done | output | 1 | One-cycle strobe when a valid frame has loaded |
| frame_err | output | 1 | One-cycle pulse when a frame had the wrong length |

## Verification
The bench builds the block with its default parameters: eight channels, 24-bit samples, 32-bit slots and four lines. These defaults exercise the full 256-count frame check, the saturating 9-bit counter for overlong frames, and two spare lines for the ignore check. Random frames in both modes drive random values on unused lines and padding bits. Directed frames cover extreme sample values, frames that are too short and too long, and a mode switch between frames, which must be reported as a framing error.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Controller states
    typedef enum logic [0:0] {
        S_WAIT_SYNC = 1'b0,
        S_COLLECT   = 1'b1
    } tdm_state_t;

endpackage

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_pkg::*;
#(
    parameter int FRAME_LONG = 256,
    parameter int CNT_W      = $clog2(FRAME_LONG) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             mode_128,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             bit_valid,
    output logic             frame_ok,
    output logic             frame_done,
    output logic             frame_err
);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_LONG);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_LONG / 2);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    tdm_state_t       state_q, state_d;
    logic             fsync_q;
    logic             start;
    logic             frame_bad;
    logic [CNT_W-1:0] frame_len;

    assign start     = fsync & ~fsync_q;
    assign frame_len = mode_128 ? LEN_SHORT : LEN_LONG;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_SYNC: if (start) state_d = S_COLLECT;
            S_COLLECT:   state_d = S_COLLECT;
            default:     state_d = S_WAIT_SYNC;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT_SYNC;
        else        state_q <= state_d;
    end

    // Frame-clock history and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q <= 1'b1;
            bit_cnt <= '0;
        end else begin
            fsync_q <= fsync;
            if (start)
                bit_cnt <= '0;
            else if (state_q == S_COLLECT && bit_cnt != '1)
                bit_cnt <= bit_cnt + ONE;
        end
    end

    assign bit_valid = (state_q == S_COLLECT) && !start && (bit_cnt < frame_len);
    assign frame_ok  = (state_q == S_COLLECT) && start && (bit_cnt == frame_len - ONE);
    assign frame_bad = (state_q == S_COLLECT) && start && (bit_cnt != frame_len - ONE);

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            frame_done <= frame_ok;
            frame_err  <= frame_bad;
        end
    end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
    parameter int NCH      = 8,
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int POS_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [POS_W-1:0]        slot_pos,
    input  logic                    bit_valid,
    input  logic                    mode_128,
    input  logic [1:0]              sd,
    output logic [NCH*SAMPLE_W-1:0] cap
);
    localparam int BIT_W  = $clog2(SLOT_W);
    localparam int SLOT_X = $clog2(NCH);
    localparam int HALF   = NCH / 2;
    localparam logic [BIT_W-1:0] SAMP_LIM = BIT_W'(SAMPLE_W);

    logic [SLOT_X-1:0] slot_full;
    logic [SLOT_X-2:0] slot_half;
    logic [BIT_W-1:0]  bit_pos;
    logic              in_sample;

    assign bit_pos   = slot_pos[BIT_W-1:0];
    assign slot_full = slot_pos[BIT_W +: SLOT_X];
    assign slot_half = slot_pos[BIT_W +: SLOT_X-1];
    assign in_sample = bit_valid && (bit_pos < SAMP_LIM);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic                sel;
        logic                din;
        logic [SAMPLE_W-1:0] shreg;

        if (ch < HALF) begin : g_lo
            assign sel = mode_128 ? (slot_half == (SLOT_X-1)'(ch))
                                  : (slot_full == SLOT_X'(ch));
            assign din = sd[0];
        end else begin : g_hi
            assign sel = mode_128 ? (slot_half == (SLOT_X-1)'(ch - HALF))
                                  : (slot_full == SLOT_X'(ch));
            assign din = mode_128 ? sd[1] : sd[0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                shreg <= '0;
            else if (in_sample && sel)
                shreg <= {shreg[SAMPLE_W-2:0], din};
        end

        assign cap[ch*SAMPLE_W +: SAMPLE_W] = shreg;
    end
endmodule

// File: rtl/tdm_out_bank.sv
module tdm_out_bank #(
    parameter int W = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/tdm8_deser.sv
module tdm8_deser #(
    parameter int NCH      = 8,
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int NLINES   = 4
) (
    input  logic                    bclk,
    input  logic                    rst_n,
    input  logic                    fsync,
    input  logic                    mode_128,
    input  logic [NLINES-1:0]       sdin,
    output logic [NCH*SAMPLE_W-1:0] samples,
    output logic                    frame_done,
    output logic                    frame_err
);
    localparam int FRAME_LONG = NCH * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_LONG) + 1;
    localparam int OUT_W      = NCH * SAMPLE_W;

    logic [CNT_W-1:0] bit_cnt;
    logic             bit_valid;
    logic             frame_ok;
    logic [OUT_W-1:0] cap;

    tdm_frame_fsm #(.FRAME_LONG(FRAME_LONG), .CNT_W(CNT_W)) i_fsm (
        .clk        (bclk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .mode_128   (mode_128),
        .bit_cnt    (bit_cnt),
        .bit_valid  (bit_valid),
        .frame_ok   (frame_ok),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    tdm_slot_router #(
        .NCH(NCH), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(CNT_W-1)
    ) i_router (
        .clk       (bclk),
        .rst_n     (rst_n),
        .slot_pos  (bit_cnt[CNT_W-2:0]),
        .bit_valid (bit_valid),
        .mode_128  (mode_128),
        .sd        (sdin[1:0]),
        .cap       (cap)
    );

    tdm_out_bank #(.W(OUT_W)) i_bank (
        .clk   (bclk),
        .rst_n (rst_n),
        .load  (frame_ok),
        .d     (cap),
        .q     (samples)
    );

    // Lines beyond the second never carry data in either mode
    if (NLINES > 2) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^sdin[NLINES-1:2];
    end
endmodule

// File: rtl/tdm8_deser_chk.sv
module tdm8_deser_chk #(
    parameter int OUT_W = 192
) (
    input logic             bclk,
    input logic             rst_n,
    input logic             fsync,
    input logic [OUT_W-1:0] samples,
    input logic             frame_done,
    input logic             frame_err
);
    a_r10_done_err_exclusive: assert property (@(posedge bclk) disable iff (!rst_n)
        !(frame_done && frame_err));

    a_r7_hold_without_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
        !frame_done |-> $stable(samples));

    a_r7_done_single_cycle: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r8_err_single_cycle: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r8_err_keeps_samples: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_err |-> $stable(samples));

    a_r2_done_after_rise: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_done |-> ($past(fsync) && !$past(fsync, 2)));
endmodule

bind tdm8_deser tdm8_deser_chk #(.OUT_W(NCH*SAMPLE_W)) i_chk (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .samples    (samples),
    .frame_done (frame_done),
    .frame_err  (frame_err)
);

// File: tb/test_tdm8_deser.sv
module test_tdm8_deser;
    localparam int W = 192;

    logic         bclk = 1'b0;
    logic         rst_n;
    logic         fsync;
    logic         mode_128;
    logic [3:0]   sdin;
    logic [W-1:0] samples;
    logic         frame_done;
    logic         frame_err;

    always #4 bclk = ~bclk;

    tdm8_deser i_tdm8_deser (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .mode_128(mode_128),
        .sdin(sdin), .samples(samples), .frame_done(frame_done), .frame_err(frame_err)
    );

    int           checks = 0;
    int           failures = 0;
    logic [W-1:0] exp_out;
    logic [W-1:0] prev_data;
    int           prev_len;
    bit           prev_mode;
    bit           have_prev = 0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nominal(input bit m);
        return m ? 128 : 256;
    endfunction

    function automatic logic [W-1:0] rand_data();
        logic [W-1:0] d;
        for (int c = 0; c < 8; c++) d[c*24 +: 24] = 24'($urandom());
        return d;
    endfunction

    // Sends one frame of len bit clocks; checks the previous frame's result
    task automatic send_frame(input bit m, input int len, input logic [W-1:0] d);
        for (int j = 0; j < len; j++) begin
            @(negedge bclk);
            if (j == 1) begin
                if (!have_prev) begin
                    chk(frame_done == 1'b0, "R9 done", W'(frame_done), W'(0));
                    chk(frame_err == 1'b0, "R9 err", W'(frame_err), W'(0));
                end else if (prev_len == nominal(m) && prev_mode == m) begin
                    chk(frame_done == 1'b1, "R7 strobe", W'(frame_done), W'(1));
                    chk(frame_err == 1'b0, "R8 no_err", W'(frame_err), W'(0));
                    chk(samples == prev_data, m ? "R4 R5 R6 data" : "R3 R5 R6 data",
                        samples, prev_data);
                    exp_out = prev_data;
                end else begin
                    chk(frame_err == 1'b1, "R8 err", W'(frame_err), W'(1));
                    chk(frame_done == 1'b0, "R8 no_done", W'(frame_done), W'(0));
                    chk(samples == exp_out, "R8 hold", samples, exp_out);
                end
            end
            if (j == 2 && have_prev) begin
                chk(frame_done == 1'b0, "R7 pulse", W'(frame_done), W'(0));
                chk(frame_err == 1'b0, "R8 pulse", W'(frame_err), W'(0));
            end
            if (j == len - 1)
                chk(samples == exp_out, "R7 stable", samples, exp_out);
            mode_128 = m;
            fsync    = (j < len / 2);
            sdin     = 4'($urandom());
            if (j >= 1 && (j - 1) < nominal(m)) begin
                int b, slot, pos;
                b    = j - 1;
                slot = b / 32;
                pos  = b % 32;
                if (pos < 24) begin
                    sdin[0] = d[slot*24 + 23 - pos];
                    if (m) sdin[1] = d[(slot+4)*24 + 23 - pos];
                end
            end
        end
        have_prev = 1;
        prev_len  = len;
        prev_mode = m;
        prev_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge bclk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        bit m;
        void'($urandom(32'h1d5e_a7c3));
        rst_n = 0; fsync = 0; mode_128 = 0; sdin = '0; exp_out = '0;
        repeat (4) @(negedge bclk);
        rst_n = 1;
        @(negedge bclk);
        // R1 reset state
        chk(samples == '0, "R1 samples", samples, '0);
        chk(frame_done == 1'b0, "R1 done", W'(frame_done), W'(0));
        chk(frame_err == 1'b0, "R1 err", W'(frame_err), W'(0));
        repeat (3) @(negedge bclk);

        // Arm frame (R9), then directed extremes in 256 mode (R2 R3)
        send_frame(0, 256, rand_data());
        d = {24'h800000, 24'h7FFFFF, 24'h000000, 24'hFFFFFF,
             24'h000001, 24'hA5A5A5, 24'h5A5A5A, 24'h800001};
        send_frame(0, 256, d);
        send_frame(0, 256, rand_data());
        // Short and long frames in 256 mode (R8)
        send_frame(0, 200, rand_data());
        send_frame(0, 260, rand_data());
        send_frame(0, 256, rand_data());
        // Mode switch gives a framing error, then 128 mode (R4 R8)
        send_frame(1, 128, rand_data());
        d = {24'h7FFFFF, 24'h800000, 24'hFFFFFF, 24'h000001,
             24'h123456, 24'hFEDCBA, 24'h000000, 24'hC00003};
        send_frame(1, 128, d);
        send_frame(1, 127, rand_data());
        send_frame(1, 129, rand_data());
        send_frame(1, 128, rand_data());
        // Random blocks with random mode and occasional bad length
        for (int blk = 0; blk < 6; blk++) begin
            m = 1'($urandom());
            for (int f = 0; f < 4; f++) begin
                int len;
                len = nominal(m);
                if ($urandom() % 5 == 0) len = len + 1 + int'($urandom() % 5);
                send_frame(m, len, rand_data());
            end
        end
        // Closing frame so the last one is checked
        send_frame(m, nominal(m), rand_data());
        repeat (4) @(negedge bclk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule